// File: doc/BRIEF.md
# Selectable-Ratio Clock Divider

This block takes two free-running reference clocks and produces one clock output. A select input picks which reference feeds the divider. The hand-over between the two references is glitch-free: the old source is switched off on one of its own falling edges, and only then is the new source switched on, on one of its falling edges. A 3-bit code chooses one of eight fixed division factors: 1, 2, 3, 4, 5, 6, 8 or 16. Odd factors use a falling-edge helper register, so every divided output has a high time of exactly half its period.

The divisor in use is reloaded only when a divided period ends. A code change therefore never shortens or stretches the period that is under way. An output-enable input either drives the divided clock or releases the output to high impedance. At integration the code, select and enable are tied to their default levels: code 000 (pass-through), select 0 (first reference) and enable 1 (driven). An active-low asynchronous reset clears the divider and holds the output low until the first full divided period has elapsed.

Top module: `clkdiv_sel_top`

## Requirements
- R1: Codes 001, 010, 011, 100, 101, 110 and 111 give an output period of 2, 3, 4, 5, 6, 8 and 16 periods of the selected reference, in that order of code value.
- R2: Code 000 passes the selected reference through undivided: the output period and high time equal those of the reference.
- R3: For every divide factor above 1, odd ones included, the output high time is exactly half the output period.
- R4: sel_b = 0 routes clk_a to the divider and sel_b = 1 routes clk_b. The output period then scales with the selected reference.
- R5: A change of sel_b never produces an output phase shorter than the steady-state phase for the current divide factor, measured against the faster reference. The two internal source enables are never both active.
- R6: A new code takes effect only at a divided-period boundary. The period in progress completes at the old factor, and the next period uses the new one.
- R7: With oe = 0 the output is not driven (high impedance). With oe = 1 the divided clock is driven on the output.
- R8: While rst_n is low the output is low. After release, the selected reference reaches the divider on its (SYNC_STAGES+1)-th rising edge. The first output rising edge then coincides with the divider's N-th input edge, which is rising edge SYNC_STAGES+N of the selected reference.

Ports of the top module:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Reference clock selected when sel_b = 0 |
| clk_b | input | 1 | Reference clock selected when sel_b = 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_b | input | 1 | Reference select: 0 = clk_a, 1 = clk_b |
| ratio_code | input | 3 | Divide-factor code (000 = divide by 1) |
| oe | input | 1 | 1 = drive output, 0 = high impedance |
| clk_out | output | 1 | Divided clock, tri-stated when oe = 0 |

## Verification
The embedded properties check four things on every edge of the clock they sample:
- the two source enables of the selector are never active together;
- the divide counter stays below the loaded factor;
- the loaded factor changes only on a wrap edge;
- the output stays low until the first wrap.

Other behaviour is visible only over whole output periods or at the pin, so only the bench scenarios can show it: the measured period and high time for all eight codes on both references, the phase widths across a reference switch, the boundary-aligned code change, the reset-to-first-edge latency, and the released output while oe is low.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
   localparam int unsigned CODE_W    = 3;
   localparam int unsigned MAX_RATIO = 16;
   localparam int unsigned RATIO_W   = $clog2(MAX_RATIO) + 1;

   typedef logic [CODE_W-1:0]  code_t;
   typedef logic [RATIO_W-1:0] ratio_t;

   // decode of the 3-bit factor code; the mapping is fixed by the block's spec
   function automatic ratio_t code_to_ratio(input code_t c);
      case (c)
         3'd0:    return ratio_t'(1);
         3'd1:    return ratio_t'(2);
         3'd2:    return ratio_t'(3);
         3'd3:    return ratio_t'(4);
         3'd4:    return ratio_t'(5);
         3'd5:    return ratio_t'(6);
         3'd6:    return ratio_t'(8);
         default: return ratio_t'(16);
      endcase
   endfunction

   // cycles the rising-edge register stays high; odd factors add half a cycle later
   function automatic ratio_t rise_high_len(input ratio_t n);
      return (n == ratio_t'(1)) ? '0 : (n >> 1);
   endfunction
endpackage

// File: rtl/clkdiv_glitchless_sel.sv
`timescale 1ns/1ps
module clkdiv_glitchless_sel #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_a,
   input  logic clk_b,
   input  logic rst_n,
   input  logic sel_b,
   output logic clk_o
);
   localparam int unsigned NUM_SRC = 2;

   logic [NUM_SRC-1:0] clk_in;
   logic [NUM_SRC-1:0] en;

   assign clk_in = {clk_b, clk_a};

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_leg
         logic want;
         logic en_q;
         logic sync_last;

         // request this leg only once the other leg has let go
         assign want = ((g == 1) ? sel_b : !sel_b) && !en[NUM_SRC-1-g];

         if (SYNC_STAGES == 1) begin : g_one
            logic s_q;
            always_ff @(posedge clk_in[g] or negedge rst_n) begin
               if (!rst_n) s_q <= 1'b0;
               else        s_q <= want;
            end
            assign sync_last = s_q;
         end else begin : g_chain
            logic [SYNC_STAGES-1:0] s_q;
            always_ff @(posedge clk_in[g] or negedge rst_n) begin
               if (!rst_n) s_q <= '0;
               else        s_q <= {s_q[SYNC_STAGES-2:0], want};
            end
            assign sync_last = s_q[SYNC_STAGES-1];
         end

         // enable flips only while this clock is low
         always_ff @(negedge clk_in[g] or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= sync_last;
         end
         assign en[g] = en_q;

         // R5: hand-over never overlaps the two sources
         a_r5_one_source: assert property (@(posedge clk_in[g]) disable iff (!rst_n)
            $onehot0(en));
      end
   endgenerate

   assign clk_o = |(clk_in & en);
endmodule

// File: rtl/clkdiv_ratio_core.sv
`timescale 1ns/1ps
module clkdiv_ratio_core
   import clkdiv_pkg::*;
(
   input  logic  sclk,
   input  logic  rst_n,
   input  code_t code_i,
   output logic  div_o
);
   localparam ratio_t ONE = ratio_t'(1);

   ratio_t ratio_req, ratio_cur, n_use, cnt, cnt_inc;
   logic   started, hi_r, hi_f, wrap, bypass, odd_mode;

   always_comb begin
      ratio_req = code_to_ratio(code_i);
      n_use     = started ? ratio_cur : ratio_req;
      wrap      = (cnt == n_use - ONE);
      cnt_inc   = cnt + ONE;
   end

   // period counter; the factor is reloaded only on the wrap edge
   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         started   <= 1'b0;
         ratio_cur <= ONE;
         hi_r      <= 1'b0;
      end else if (wrap) begin
         cnt       <= '0;
         started   <= 1'b1;
         ratio_cur <= ratio_req;
         hi_r      <= (rise_high_len(ratio_req) != '0);
      end else begin
         cnt       <= cnt_inc;
         hi_r      <= started && (cnt_inc < rise_high_len(ratio_cur));
      end
   end

   // half-cycle delayed copy widens odd-factor high phase to N/2
   always_ff @(negedge sclk or negedge rst_n) begin
      if (!rst_n) hi_f <= 1'b0;
      else        hi_f <= hi_r;
   end

   assign bypass   = started && (ratio_cur == ONE);
   assign odd_mode = started && ratio_cur[0] && !bypass;
   assign div_o    = bypass ? sclk : (odd_mode ? (hi_r | hi_f) : hi_r);

   // R6: loaded factor holds between boundaries
   a_r6_ratio_hold: assert property (@(posedge sclk) disable iff (!rst_n)
      (started && !wrap) |=> $stable(ratio_cur));

   // R1: counter never passes the loaded factor
   a_r1_cnt_range: assert property (@(posedge sclk) disable iff (!rst_n)
      started |-> (cnt < ratio_cur));

   // R8: output stays low until the first full period has run
   a_r8_quiet_start: assert property (@(posedge sclk) disable iff (!rst_n)
      !started |-> !div_o);
endmodule

// File: rtl/clkdiv_sel_top.sv
`timescale 1ns/1ps
module clkdiv_sel_top
   import clkdiv_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_a,
   input  logic              clk_b,
   input  logic              rst_n,
   input  logic              sel_b,
   input  logic [CODE_W-1:0] ratio_code,
   input  logic              oe,
   output wire               clk_out
);
   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if ((1 << (RATIO_W - 1)) < MAX_RATIO) begin : g_bad_width
         $error("RATIO_W too narrow for MAX_RATIO");
      end
   endgenerate

   logic sel_clk;
   logic div_clk;

   clkdiv_glitchless_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
      .clk_a (clk_a),
      .clk_b (clk_b),
      .rst_n (rst_n),
      .sel_b (sel_b),
      .clk_o (sel_clk)
   );

   clkdiv_ratio_core u_core (
      .sclk   (sel_clk),
      .rst_n  (rst_n),
      .code_i (ratio_code),
      .div_o  (div_clk)
   );

   // R7: release the pin when not enabled
   assign clk_out = oe ? div_clk : 1'bz;
endmodule

// File: tb/tb_clkdiv_sel_top.sv
`timescale 1ns/1ps
module tb_clkdiv_sel_top;
   localparam real TA   = 20.0;   // 50 MHz
   localparam real TB   = 32.0;
   localparam int  SYNC = 2;

   logic       clk_a = 1'b0;
   logic       clk_b = 1'b0;
   logic       rst_n;
   logic       sel_b;
   logic [2:0] ratio_code;
   logic       oe;
   wire        q_line;

   pullup (q_line);

   always #(TA/2) clk_a = ~clk_a;
   always #(TB/2) clk_b = ~clk_b;

   clkdiv_sel_top #(.SYNC_STAGES(SYNC)) dut (
      .clk_a      (clk_a),
      .clk_b      (clk_b),
      .rst_n      (rst_n),
      .sel_b      (sel_b),
      .ratio_code (ratio_code),
      .oe         (oe),
      .clk_out    (q_line)
   );

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 0;

   // phase-width monitor
   bit  track = 0;
   real last_edge = 0.0;
   real min_phase = 1.0e9;
   always @(q_line) begin
      if (track && ($realtime - last_edge) < min_phase) min_phase = $realtime - last_edge;
      last_edge = $realtime;
   end

   // release monitor
   bit zwatch = 0;
   int low_seen = 0;
   int fall_cnt = 0;
   always @(negedge q_line) begin
      fall_cnt++;
      if (zwatch) low_seen++;
   end

   function automatic int ratio_of(input int c);
      case (c)
         0: return 1;  1: return 2;  2: return 3;  3: return 4;
         4: return 5;  5: return 6;  6: return 8;  default: return 16;
      endcase
   endfunction

   task automatic chk_real(input string tag, input real act, input real exp);
      checks++;
      if ((act - exp) > 0.01 || (exp - act) > 0.01) begin
         fails++;
         $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
      end
   endtask

   task automatic chk_ge(input string tag, input real act, input real lim);
      checks++;
      if (act < lim - 0.01) begin
         fails++;
         $display("FAIL %s actual=%0.3f expected>=%0.3f", tag, act, lim);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (3) @(posedge q_line);
   endtask

   task automatic measure(output real per, output real hi);
      real t0, t1, t2;
      @(posedge q_line); t0 = $realtime;
      @(negedge q_line); t1 = $realtime;
      @(posedge q_line); t2 = $realtime;
      per = t2 - t0;
      hi  = t1 - t0;
   endtask

   initial begin
      real t0, t1, t2, per, hi, tin;
      int  f0;
      rst_n = 1'b0; sel_b = 1'b0; ratio_code = 3'd3; oe = 1'b1;

      // R8: low in reset, first rise after SYNC+N reference edges
      #45;
      chk_int("R8 output low in reset", int'(q_line), 0);
      @(negedge clk_a);
      rst_n = 1'b1;
      t0 = $realtime;
      @(posedge q_line);
      chk_real("R8 first rising edge time", $realtime - t0, TA/2 + (SYNC + 4 - 1) * TA);

      // R1 R2 R3 R4: every code on both references
      for (int s = 0; s < 2; s++) begin
         for (int c = 0; c < 8; c++) begin
            sel_b = s[0];
            ratio_code = c[2:0];
            tin = (s == 0) ? TA : TB;
            settle();
            measure(per, hi);
            if (c == 0) begin
               chk_real($sformatf("R2 R4 bypass period sel=%0d", s), per, tin);
               chk_real($sformatf("R2 R4 bypass high sel=%0d", s), hi, tin / 2.0);
            end else begin
               chk_real($sformatf("R1 R4 period code=%0d sel=%0d", c, s), per, ratio_of(c) * tin);
               chk_real($sformatf("R3 R4 high code=%0d sel=%0d", c, s), hi, ratio_of(c) * tin / 2.0);
            end
         end
      end

      // R6: code change mid-period waits for the boundary
      sel_b = 1'b0; ratio_code = 3'd3;
      settle();
      @(posedge q_line); t0 = $realtime;
      #(TA + 3.0) ratio_code = 3'd7;
      @(posedge q_line); t1 = $realtime;
      @(posedge q_line); t2 = $realtime;
      chk_real("R6 old factor finishes (4->16)", t1 - t0, 4 * TA);
      chk_real("R6 new factor applies (4->16)", t2 - t1, 16 * TA);
      @(posedge q_line); t0 = $realtime;
      #(5 * TA + 3.0) ratio_code = 3'd2;
      @(posedge q_line); t1 = $realtime;
      @(posedge q_line); t2 = $realtime;
      chk_real("R6 old factor finishes (16->3)", t1 - t0, 16 * TA);
      chk_real("R6 new factor applies (16->3)", t2 - t1, 3 * TA);

      // R5: reference switch, bypass and divide-by-3
      ratio_code = 3'd0;
      settle();
      min_phase = 1.0e9; track = 1;
      #(7.0) sel_b = 1'b1;
      #(20 * TA) sel_b = 1'b0;
      #(20 * TA) track = 0;
      chk_ge("R5 bypass min phase across switch", min_phase, TA / 2.0);
      ratio_code = 3'd2;
      settle();
      min_phase = 1.0e9; track = 1;
      #(13.0) sel_b = 1'b1;
      #(20 * TA) sel_b = 1'b0;
      #(20 * TA) track = 0;
      chk_ge("R5 div3 min phase across switch", min_phase, 1.5 * TA);

      // R7: released while disabled, driven again when enabled
      ratio_code = 3'd1;
      settle();
      oe = 1'b0;
      #1.0;
      low_seen = 0; zwatch = 1;
      #(30 * TA);
      zwatch = 0;
      chk_int("R7 no drive low while disabled", low_seen, 0);
      chk_int("R7 line at pull level while disabled", int'(q_line), 1);
      oe = 1'b1;
      f0 = fall_cnt;
      #(10 * TA);
      chk_ge("R7 toggles when enabled", real'(fall_cnt - f0), 4.0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule